// File: doc/BRIEF.md
# Command-Mode Panel Bus Sequencer

This block turns a stream of command words into transfers on an 8-bit parallel bus toward a display panel that keeps its own frame memory. The bus has a register-select line, an active-low write strobe and an active-low read strobe. Each command word carries three fields: a data byte, the level for the register-select line, and an opcode. The opcodes cover:

- command and data writes;
- streaming a frame of pixel bytes from a separate pixel input;
- reads of the panel's status or frame memory;
- waiting for a vertical sync pulse;
- a no-op;
- raising a command interrupt.

Command words come from a FIFO through a valid/ready pair, and the sequencer takes one word whenever it is idle. The result of a read is kept in a status word. That word holds the byte returned by the panel, the register-select level used for the read, a completion bit and a continue bit. Two interrupt outputs are available, one for read completion and one for the interrupt opcode. Each is a sticky flag gated by its own mask input and cleared by its own acknowledge input.

Top module: `panel_cmd_seq`

## Requirements
- R1: After reset the write and read strobes are high, the bus driver is off, the sequencer is ready for a command, the status word is zero and both interrupt outputs are low.
- R2: A write spends one setup cycle with the strobes high, then drives the write strobe low for exactly two cycles, then spends one hold cycle with the strobe high. The sequencer does not take a new command word during these four cycles.
- R3: The command word is 12 bits. Bits 7:0 are the data byte, bit 8 is the register-select level and bits 11:9 are the opcode. During the four cycles of a transfer the bus carries the data byte, and the register-select line carries bit 8.
- R4: Opcode 0 is a read: register-select 0 reads the panel status, and register-select 1 reads frame memory. The read uses the same setup/strobe/hold timing on the read strobe, with the bus driver off. The input byte is captured at the clock edge where the read strobe returns high. Status bits 7:0 take that byte, bit 8 takes the register-select level and bit 9 (completion) is set.
- R5: Status bit 9 is cleared when a read command is taken. Status bit 10 (continue) takes the command-valid input as seen at the capture edge.
- R6: Opcode 2 streams a frame of FRAME_BYTES bytes. Each byte comes from the pixel input through a valid/ready pair and is written with R2 timing, using the register-select level of the command word. Pixel-ready is high only while a byte is awaited. The sequencer returns to idle after the last byte.
- R7: Opcode 3 stalls the sequencer until a vertical sync pulse is seen while stalled. A pulse present in the cycle the command is taken is ignored.
- R8: Opcodes 4, 6 and 7 each take one word per cycle and cause no bus activity.
- R9: Opcode 5 sets a command flag. The command interrupt output is the flag while its mask input is low. An acknowledge clears the flag, and a set in the same cycle wins.
- R10: Each read completion sets a read flag. The read interrupt output is the flag while its mask input is low. An acknowledge clears the flag, and a set in the same cycle wins.
- R11: The two strobes are never low together, and the bus driver is enabled only during the four cycles of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | A command word is available |
| cmdWord | input | DATA_W+4 | Command word: data, register-select, opcode |
| cmdReady | output | 1 | The command word is taken this cycle when valid |
| pixValid | input | 1 | A pixel byte is available |
| pixData | input | DATA_W | Pixel byte for frame streaming |
| pixReady | output | 1 | The pixel byte is taken this cycle when valid |
| vsyncPulse | input | 1 | Vertical sync pulse from the panel |
| busOut | output | DATA_W | Bus data driven toward the panel |
| busIn | input | DATA_W | Bus data returned by the panel |
| busOe | output | 1 | Bus output enable |
| selA0 | output | 1 | Register-select line |
| wrN | output | 1 | Write strobe, active low |
| rdN | output | 1 | Read strobe, active low |
| panelStatus | output | DATA_W+3 | Read result: byte, register-select, completion, continue |
| maskRdStat | input | 1 | Masks the read interrupt |
| maskCmd | input | 1 | Masks the command interrupt |
| ackRdStat | input | 1 | Clears the read flag |
| ackCmd | input | 1 | Clears the command flag |
| irqRdStat | output | 1 | Read completion interrupt |
| irqCmd | output | 1 | Command interrupt |

## Verification
The bench builds the block with DATA_W at 8 and FRAME_BYTES at 3. A short frame still covers the first-byte and last-byte transitions: going back to the pixel wait after a middle byte, and going back to idle after the final one. A pixel source with gaps holds the sequencer in its pixel wait between bytes. Reads are run both with another command queued and with none queued, so the continue bit is seen in both states. A vertical sync pulse placed in the same cycle the wait command is taken shows that such a pulse is ignored.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE1,
    ST_STROBE2,
    ST_HOLD,
    ST_PIXWAIT,
    ST_VWAIT
  } seqState_t;

  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_WRITE = 3'd1;
  localparam logic [2:0] OP_FRAME = 3'd2;
  localparam logic [2:0] OP_VSYNC = 3'd3;
  localparam logic [2:0] OP_IRQ   = 3'd5;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCmd;     // capture data byte and register-select from the word
    logic loadPix;     // capture a pixel byte, count one frame byte
    logic loadCount;   // start a frame
    logic startRead;   // clear completion bit
    logic latchRead;   // capture the panel byte
    logic setCmdFlag;  // interrupt opcode taken
  } seqStrobes_t;

endpackage

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
  import panel_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  opcode,
  input  logic        pixValid,
  input  logic        vsyncPulse,
  input  logic        cntZero,
  output logic        cmdReady,
  output logic        pixReady,
  output logic        wrN,
  output logic        rdN,
  output logic        busOe,
  output seqStrobes_t strb
);

  seqState_t state, nextState;
  logic      isRead, isReadNext;
  logic      inXfer, inStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      isRead <= 1'b0;
    end else begin
      state  <= nextState;
      isRead <= isReadNext;
    end
  end

  always_comb begin
    nextState  = state;
    isReadNext = isRead;
    strb       = '0;
    case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          case (opcode)
            OP_READ: begin
              strb.loadCmd   = 1'b1;
              strb.startRead = 1'b1;
              isReadNext     = 1'b1;
              nextState      = ST_SETUP;
            end
            OP_WRITE: begin
              strb.loadCmd = 1'b1;
              isReadNext   = 1'b0;
              nextState    = ST_SETUP;
            end
            OP_FRAME: begin
              strb.loadCmd   = 1'b1;
              strb.loadCount = 1'b1;
              isReadNext     = 1'b0;
              nextState      = ST_PIXWAIT;
            end
            OP_VSYNC: nextState = ST_VWAIT;
            OP_IRQ:   strb.setCmdFlag = 1'b1;
            default:  nextState = ST_IDLE;
          endcase
        end
      end
      ST_PIXWAIT: begin
        if (pixValid) begin
          strb.loadPix = 1'b1;
          nextState    = ST_SETUP;
        end
      end
      ST_SETUP:   nextState = ST_STROBE1;
      ST_STROBE1: nextState = ST_STROBE2;
      ST_STROBE2: begin
        strb.latchRead = isRead;
        nextState      = ST_HOLD;
      end
      ST_HOLD:  nextState = cntZero ? ST_IDLE : ST_PIXWAIT;
      ST_VWAIT: if (vsyncPulse) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign inStrobe = (state == ST_STROBE1) || (state == ST_STROBE2);
  assign inXfer   = inStrobe || (state == ST_SETUP) || (state == ST_HOLD);
  assign cmdReady = (state == ST_IDLE);
  assign pixReady = (state == ST_PIXWAIT);
  assign wrN      = !(inStrobe && !isRead);
  assign rdN      = !(inStrobe && isRead);
  assign busOe    = inXfer && !isRead;

endmodule

// File: rtl/panel_seq_dp.sv
module panel_seq_dp
  import panel_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FRAME_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [DATA_W:0]   cmdField,
  input  logic [DATA_W-1:0] pixData,
  input  logic [DATA_W-1:0] busIn,
  input  logic              cmdValid,
  input  logic              maskRdStat,
  input  logic              maskCmd,
  input  logic              ackRdStat,
  input  logic              ackCmd,
  output logic              cntZero,
  output logic [DATA_W-1:0] busOut,
  output logic              selA0,
  output logic [DATA_W+2:0] panelStatus,
  output logic              irqRdStat,
  output logic              irqCmd
);

  localparam int CNT_W = $clog2(FRAME_BYTES + 1);
  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_BYTES);
  localparam int OK_BIT = DATA_W + 1;

  logic [DATA_W-1:0] dataReg;
  logic              a0Reg;
  logic [CNT_W-1:0]  byteCnt;
  logic [DATA_W+2:0] statusReg;
  logic              rdFlag, cmdFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      a0Reg   <= 1'b0;
    end else if (strb.loadCmd) begin
      dataReg <= cmdField[DATA_W-1:0];
      a0Reg   <= cmdField[DATA_W];
    end else if (strb.loadPix) begin
      dataReg <= pixData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) byteCnt <= '0;
    else if (strb.loadCount) byteCnt <= FRAME_CNT;
    else if (strb.loadPix && byteCnt != '0) byteCnt <= byteCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= '0;
    end else if (strb.latchRead) begin
      statusReg <= {cmdValid, 1'b1, a0Reg, busIn};
    end else if (strb.startRead) begin
      statusReg[OK_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdFlag  <= 1'b0;
      cmdFlag <= 1'b0;
    end else begin
      if (strb.latchRead) rdFlag <= 1'b1;
      else if (ackRdStat) rdFlag <= 1'b0;
      if (strb.setCmdFlag) cmdFlag <= 1'b1;
      else if (ackCmd)     cmdFlag <= 1'b0;
    end
  end

  assign cntZero     = (byteCnt == '0);
  assign busOut      = dataReg;
  assign selA0       = a0Reg;
  assign panelStatus = statusReg;
  assign irqRdStat   = rdFlag && !maskRdStat;
  assign irqCmd      = cmdFlag && !maskCmd;

endmodule

// File: rtl/panel_cmd_seq.sv
module panel_cmd_seq
  import panel_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FRAME_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [DATA_W+3:0] cmdWord,
  output logic              cmdReady,
  input  logic              pixValid,
  input  logic [DATA_W-1:0] pixData,
  output logic              pixReady,
  input  logic              vsyncPulse,
  output logic [DATA_W-1:0] busOut,
  input  logic [DATA_W-1:0] busIn,
  output logic              busOe,
  output logic              selA0,
  output logic              wrN,
  output logic              rdN,
  output logic [DATA_W+2:0] panelStatus,
  input  logic              maskRdStat,
  input  logic              maskCmd,
  input  logic              ackRdStat,
  input  logic              ackCmd,
  output logic              irqRdStat,
  output logic              irqCmd
);

  seqStrobes_t strb;
  logic        cntZero;

  panel_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .opcode     (cmdWord[DATA_W+3:DATA_W+1]),
    .pixValid   (pixValid),
    .vsyncPulse (vsyncPulse),
    .cntZero    (cntZero),
    .cmdReady   (cmdReady),
    .pixReady   (pixReady),
    .wrN        (wrN),
    .rdN        (rdN),
    .busOe      (busOe),
    .strb       (strb)
  );

  panel_seq_dp #(
    .DATA_W      (DATA_W),
    .FRAME_BYTES (FRAME_BYTES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cmdField    (cmdWord[DATA_W:0]),
    .pixData     (pixData),
    .busIn       (busIn),
    .cmdValid    (cmdValid),
    .maskRdStat  (maskRdStat),
    .maskCmd     (maskCmd),
    .ackRdStat   (ackRdStat),
    .ackCmd      (ackCmd),
    .cntZero     (cntZero),
    .busOut      (busOut),
    .selA0       (selA0),
    .panelStatus (panelStatus),
    .irqRdStat   (irqRdStat),
    .irqCmd      (irqCmd)
  );

endmodule

// File: rtl/panel_cmd_seq_chk.sv
module panel_cmd_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrN,
  input logic              rdN,
  input logic              busOe,
  input logic [DATA_W-1:0] busOut,
  input logic              selA0,
  input logic              statusOk,
  input logic              pixReady,
  input logic              cmdReady,
  input logic              irqCmd,
  input logic              ackCmd,
  input logic              maskCmd
);

  // R2
  wr_pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |=> !wrN ##1 wrN);

  // R3
  wr_data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> ($stable(busOut) && $stable(selA0)));

  // R11
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrN || rdN);

  // R4
  rd_bus_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !busOe);

  // R4
  rd_done_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdN) |-> statusOk);

  // R6
  pix_wait_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixReady |-> (wrN && rdN && !cmdReady));

  // R9
  irq_cmd_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqCmd) |-> ($past(ackCmd) || maskCmd));

endmodule

bind panel_cmd_seq panel_cmd_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrN      (wrN),
  .rdN      (rdN),
  .busOe    (busOe),
  .busOut   (busOut),
  .selA0    (selA0),
  .statusOk (panelStatus[DATA_W+1]),
  .pixReady (pixReady),
  .cmdReady (cmdReady),
  .irqCmd   (irqCmd),
  .ackCmd   (ackCmd),
  .maskCmd  (maskCmd)
);

// File: tb/test_panel_cmd_seq.sv
module test_panel_cmd_seq;
  localparam int DW = 8;
  localparam int FB = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic cmdValid = 1'b0, pixValid = 1'b0, vsyncPulse = 1'b0;
  logic [DW+3:0] cmdWord = '0;
  logic [DW-1:0] pixData = '0, busIn = '0;
  logic maskRdStat = 1'b0, maskCmd = 1'b0, ackRdStat = 1'b0, ackCmd = 1'b0;
  logic cmdReady, pixReady, busOe, selA0, wrN, rdN, irqRdStat, irqCmd;
  logic [DW-1:0] busOut;
  logic [DW+2:0] panelStatus;

  panel_cmd_seq #(.DATA_W(DW), .FRAME_BYTES(FB)) i_panel_cmd_seq (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  bit pixGap = 0;
  logic [DW+3:0] cmdQ[$];
  logic [DW-1:0] pixQ[$];
  logic [DW-1:0] wrLog[$];

  // Behavioural reference model
  int busy = 0, frameLeft = 0;
  bit mRead = 0, mA0 = 0, pixWait = 0, vWait = 0, mRdFlag = 0, mCmdFlag = 0;
  logic [DW-1:0] mData = '0;
  logic [DW+2:0] mStat = '0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW+3:0] w(int op, int a0, int d);
    return {op[2:0], a0[0], d[DW-1:0]};
  endfunction

  always @(negedge clk) begin
    cmdValid = (cmdQ.size() > 0);
    cmdWord  = (cmdQ.size() > 0) ? cmdQ[0] : '0;
    pixValid = (pixQ.size() > 0) && !pixGap;
    pixData  = (pixQ.size() > 0) ? pixQ[0] : '0;
  end

  always @(posedge clk) begin
    bit rdSet, cmdSet;
    rdSet = 0;
    cmdSet = 0;
    if (!rstN) begin
      busy = 0; frameLeft = 0; mRead = 0; mA0 = 0; pixWait = 0; vWait = 0;
      mRdFlag = 0; mCmdFlag = 0; mData = '0; mStat = '0;
    end else begin
      if (busy > 0) begin
        if (busy == 2 && mRead) begin
          mStat = {cmdValid, 1'b1, mA0, busIn};
          rdSet = 1;
        end
        busy--;
        if (busy == 0 && frameLeft > 0) pixWait = 1;
      end else if (vWait) begin
        if (vsyncPulse) vWait = 0;
      end else if (pixWait) begin
        if (pixValid) begin
          mData = pixData;
          void'(pixQ.pop_front());
          busy = 4; pixWait = 0; frameLeft--;
        end
      end else if (cmdValid) begin
        int op;
        op = int'(cmdWord[DW+3:DW+1]);
        void'(cmdQ.pop_front());
        case (op)
          0: begin mRead = 1; mData = cmdWord[DW-1:0]; mA0 = cmdWord[DW]; busy = 4; mStat[DW+1] = 1'b0; end
          1: begin mRead = 0; mData = cmdWord[DW-1:0]; mA0 = cmdWord[DW]; busy = 4; end
          2: begin mRead = 0; mA0 = cmdWord[DW]; frameLeft = FB; pixWait = 1; end
          3: vWait = 1;
          5: cmdSet = 1;
          default: ;
        endcase
      end
      if (ackRdStat) mRdFlag = 0;
      if (rdSet) mRdFlag = 1;
      if (ackCmd) mCmdFlag = 0;
      if (cmdSet) mCmdFlag = 1;
    end
  end

  // Per-cycle comparison against the model
  bit prevWrN = 1;
  initial forever begin
    @(negedge clk);
    #1;
    if (rstN && !done) begin
      bit strobe, eWr, eRd, eOe;
      strobe = (busy == 3 || busy == 2);
      eWr = !(strobe && !mRead);
      eRd = !(strobe && mRead);
      eOe = (busy > 0) && !mRead;
      chk(wrN == eWr, "R2 wrN", wrN, eWr);
      chk(rdN == eRd, "R4 rdN", rdN, eRd);
      chk(busOe == eOe, "R11 busOe", busOe, eOe);
      if (eOe) chk(busOut == mData, "R3 busOut", busOut, mData);
      if (busy > 0) chk(selA0 == mA0, "R3 selA0", selA0, mA0);
      chk(cmdReady == (busy == 0 && !vWait && !pixWait), "R8 cmdReady", cmdReady,
          busy == 0 && !vWait && !pixWait);
      chk(pixReady == (busy == 0 && !vWait && pixWait), "R6 pixReady", pixReady,
          busy == 0 && !vWait && pixWait);
      chk(panelStatus == mStat, "R5 panelStatus", panelStatus, mStat);
      chk(irqCmd == (mCmdFlag && !maskCmd), "R9 irqCmd", irqCmd, mCmdFlag && !maskCmd);
      chk(irqRdStat == (mRdFlag && !maskRdStat), "R10 irqRdStat", irqRdStat,
          mRdFlag && !maskRdStat);
      if (prevWrN && !wrN) wrLog.push_back(busOut);
      prevWrN = wrN;
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic drain();
    do step(); while (!(cmdQ.size() == 0 && pixQ.size() == 0 && busy == 0 && !vWait && !pixWait));
    step();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    // R1 reset state
    chk(wrN && rdN && !busOe, "R1 strobes", {wrN, rdN, busOe}, 3'b110);
    chk(cmdReady == 1'b1, "R1 cmdReady", cmdReady, 1);
    chk(panelStatus == '0 && !irqCmd && !irqRdStat, "R1 status", panelStatus, 0);
    rstN = 1'b1;
    step(2);

    // R2 R3 command write then data write
    cmdQ.push_back(w(1, 0, 'h3C));
    cmdQ.push_back(w(1, 1, 'hA5));
    drain();
    chk(wrLog.size() == 2 && wrLog[0] == 'h3C && wrLog[1] == 'hA5, "R3 written bytes",
        wrLog.size(), 2);

    // R4 R5 status read with a further word queued
    busIn = 'h5E;
    cmdQ.push_back(w(0, 0, 'h11));
    cmdQ.push_back(w(4, 0, 0));
    drain();
    chk(panelStatus == 11'h65E, "R5 status read cont", panelStatus, 'h65E);

    // R4 R5 frame memory read, nothing queued
    busIn = 'hC3;
    cmdQ.push_back(w(0, 1, 0));
    drain();
    chk(panelStatus == 11'h3C3, "R4 frame read", panelStatus, 'h3C3);
    chk(irqRdStat == 1'b1, "R10 read irq", irqRdStat, 1);
    ackRdStat = 1'b1; step(); ackRdStat = 1'b0; step();
    chk(irqRdStat == 1'b0, "R10 read ack", irqRdStat, 0);

    // R10 masked read flag
    maskRdStat = 1'b1;
    busIn = 'h0F;
    cmdQ.push_back(w(0, 0, 0));
    drain();
    chk(irqRdStat == 1'b0, "R10 masked", irqRdStat, 0);
    maskRdStat = 1'b0; step();
    chk(irqRdStat == 1'b1, "R10 unmasked", irqRdStat, 1);
    ackRdStat = 1'b1; step(); ackRdStat = 1'b0; step();

    // R8 no-ops take one word per cycle
    cmdQ.push_back(w(4, 0, 0));
    cmdQ.push_back(w(6, 1, 'hFF));
    cmdQ.push_back(w(7, 0, 'h12));
    step(4);
    chk(cmdQ.size() == 0 && wrN && rdN, "R8 noops", cmdQ.size(), 0);

    // R9 interrupt opcode
    cmdQ.push_back(w(5, 0, 0));
    drain();
    chk(irqCmd == 1'b1, "R9 irq set", irqCmd, 1);
    ackCmd = 1'b1; step(); ackCmd = 1'b0; step();
    chk(irqCmd == 1'b0, "R9 irq ack", irqCmd, 0);
    maskCmd = 1'b1;
    cmdQ.push_back(w(5, 0, 0));
    drain();
    chk(irqCmd == 1'b0, "R9 masked", irqCmd, 0);
    maskCmd = 1'b0; step();
    chk(irqCmd == 1'b1, "R9 unmasked", irqCmd, 1);
    ackCmd = 1'b1; step(); ackCmd = 1'b0; step();

    // R7 vsync wait; pulse in the accepting cycle ignored
    cmdQ.push_back(w(3, 0, 0));
    cmdQ.push_back(w(1, 0, 'h77));
    vsyncPulse = 1'b1; step(); vsyncPulse = 1'b0;
    step(5);
    chk(!cmdReady && wrN && cmdQ.size() == 1, "R7 stalled", cmdQ.size(), 1);
    vsyncPulse = 1'b1; step(); vsyncPulse = 1'b0;
    drain();
    chk(wrLog[wrLog.size()-1] == 'h77, "R7 resumed", wrLog[wrLog.size()-1], 'h77);

    // R6 frame streaming with a gapped pixel source
    wrLog.delete();
    pixGap = 1;
    cmdQ.push_back(w(2, 1, 0));
    pixQ.push_back('hAA); pixQ.push_back('hBB); pixQ.push_back('hCC);
    step(6);
    chk(pixReady == 1'b1 && wrN, "R6 waiting", pixReady, 1);
    pixGap = 0;
    drain();
    chk(wrLog.size() == FB && wrLog[0] == 'hAA && wrLog[1] == 'hBB && wrLog[2] == 'hCC,
        "R6 frame bytes", wrLog.size(), FB);
    chk(cmdReady && !pixReady, "R6 back to idle", cmdReady, 1);

    done = 1;
    summary();
    $finish;
  end

endmodule